// File: doc/BRIEF.md
# Handshake-Terminated Bus Cycle Sequencer

This block is the master side of a processor-style external bus. The core hands it one read or write request at a time. The sequencer then runs a bus cycle made of six half-clock bus states, S0 to S5. It produces the bus clock, drives the address, the direction and the write data, and raises an address strobe and a data strobe. The cycle ends when the slave answers on a two-bit acknowledge that also gives its port width, or on a bus-error line.

Both slave answers reach the state machine only through a two-stage synchroniser. That synchroniser advances on falling bus-clock edges. The sequencer tests the synchronised answer on the falling edge that ends S2. If no answer is present, it repeats S2/S3 for one whole bus clock and tests again on the next falling edge. After an answer is recognised, a read captures the data bus one falling edge later, at the end of S4. A cache-inhibit input is taken on the rising edge that opens S4. The strobes drop on the rising edge that closes S5, and the core then receives a one-clock done pulse carrying the result.

The design runs from a single clock `clk` at twice the bus-clock rate. Every `clk` edge is one bus-state boundary, and `bus_clk` is high in S0, S2 and S4. The request side is valid/ready. The core may hold `req_valid` with stable fields for as long as `req_ready` is low. A request is taken only on an edge where both are high. The response side has no back-pressure: `rsp_valid` is high for exactly one `clk` cycle and the core must take the result then. The result fields stay readable until the next cycle ends.

Top module: `bus_seq_master`

## Requirements
- R1: After reset the strobes are low, `rsp_valid` is low, `rsp_data` is zero, and `req_ready` goes high while no acknowledge or bus error is present.
- R2: `req_ready` is high only when the sequencer is idle, `bus_clk` is low and both synchronised slave answers are clear. An accepted request starts S0 on that edge, and `bus_clk` is high during S0.
- R3: `bus_astb` is high from S1 through S5, including wait clocks. On a read `bus_dstb` matches `bus_astb`. On a write `bus_dstb` rises one state later, in S2. Both strobes fall on the rising `bus_clk` edge that ends S5.
- R4: The slave answers are sampled only on falling `bus_clk` edges. An answer present at the falling edge that ends S0 gives a three-bus-clock cycle, with `rsp_valid` high 6 `clk` edges after the accepting edge. Each later falling edge at which the answer first appears adds one full bus clock (2 `clk` edges).
- R5: A read captures `bus_din` on the falling edge that follows recognition of the answer, which is the edge that ends S4. It does not capture on the recognition edge itself.
- R6: `bus_cinh` is latched on the rising edge that opens S4 and reported on `rsp_cinh` for reads. A write always reports 0.
- R7: The acknowledge code is 2'b00 for no answer, 2'b01 for an 8-bit port, 2'b10 for a 16-bit port and 2'b11 for a 32-bit port. The recognised code is returned on `rsp_port`.
- R8: Bus error wins over an acknowledge sampled on the same edge. The cycle then reports `rsp_err`=1 and `rsp_port`=2'b00, and `rsp_data` keeps its previous value.
- R9: No new cycle is accepted while an acknowledge or bus error from the finished cycle is still held by the slave after the strobes have dropped.
- R10: `rsp_valid` is a single `clk` pulse on the cycle after the strobes fall.
- R11: `bus_addr`, `bus_rnw` and, on writes, `bus_dout` keep the accepted request values for as long as the address strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the bus-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Sequencer takes the request on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | DATA_W | Last captured read data |
| rsp_err | output | 1 | Cycle ended by bus error |
| rsp_port | output | 2 | Recognised port-width code |
| rsp_cinh | output | 1 | Latched cache-inhibit (reads only) |
| bus_clk | output | 1 | Bus clock, high in even bus states |
| bus_addr | output | ADDR_W | Bus address |
| bus_rnw | output | 1 | 1 = read cycle |
| bus_dout | output | DATA_W | Write data on the bus (zero on reads) |
| bus_astb | output | 1 | Address strobe, active high |
| bus_dstb | output | 1 | Data strobe, active high |
| bus_din | input | DATA_W | Read data from the slave |
| bus_ack | input | 2 | Slave acknowledge with port-width code |
| bus_berr | input | 1 | Slave bus error |
| bus_cinh | input | 1 | Slave cache-inhibit |

## Verification
The assertions assume a well-behaved slave and core. The slave keeps its answer asserted until after the address strobe falls, and never raises an answer while the sequencer is idle with a request pending. The core changes request fields only outside an accepting edge. The bench's slave model keeps to these rules. It drives every bus input on falling `clk` edges. It raises its answer at a chosen half-clock offset and releases it only after it has seen the strobes drop, sometimes several half-clocks late. It presents valid read data and cache-inhibit only in the single half-clock before the edge that must capture them, so an edge chosen too early or too late would latch the wrong value.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int ACK_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_S0,
    ST_S1,
    ST_S2,
    ST_S3,
    ST_S4,
    ST_S5
  } bstate_t;

  typedef struct packed {
    logic             err;
    logic [ACK_W-1:0] port;
  } term_t;
endpackage

// File: rtl/bseq_sync.sv
module bseq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stg;
      always_ff @(posedge clk) begin
        if (!rst_n)  stg <= '0;
        else if (en) stg <= d;
      end
      assign q = stg;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stg;
      always_ff @(posedge clk) begin
        if (!rst_n)  stg <= '0;
        else if (en) stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ACK_W-1:0] ack_s,
  input  logic             berr_s,
  output logic             phase_hi,
  output logic             req_ready,
  output logic             accept,
  output logic             take_term,
  output logic             take_data,
  output logic             finish,
  output logic             astb,
  output logic             dstb_late
);
  bstate_t state, state_nx;
  logic    line_busy;

  // bus clock phase: high half precedes a falling edge
  always_ff @(posedge clk) begin
    if (!rst_n) phase_hi <= 1'b0;
    else        phase_hi <= ~phase_hi;
  end

  assign line_busy = (|ack_s) | berr_s;
  assign req_ready = (state == ST_IDLE) && !phase_hi && !line_busy;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (accept) state_nx = ST_S0;
      ST_S0:   state_nx = ST_S1;
      ST_S1:   state_nx = ST_S2;
      ST_S2:   state_nx = ST_S3;
      ST_S3:   state_nx = line_busy ? ST_S4 : ST_S2;  // wait clock = S2/S3 again
      ST_S4:   state_nx = ST_S5;
      ST_S5:   state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign take_term = (state == ST_S3) && line_busy;  // rising edge opening S4
  assign take_data = (state == ST_S4);               // falling edge closing S4
  assign finish    = (state == ST_S5);
  assign astb      = (state inside {ST_S1, ST_S2, ST_S3, ST_S4, ST_S5});
  assign dstb_late = (state inside {ST_S2, ST_S3, ST_S4, ST_S5});
endmodule

// File: rtl/bseq_capture.sv
module bseq_capture
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              take_term,
  input  logic              take_data,
  input  logic              finish,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ACK_W-1:0]  ack_s,
  input  logic              berr_s,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_cinh,
  output logic              write_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output term_t             term_q,
  output logic              cinh_q,
  output logic              done_q
);
  term_t term_nx;

  always_comb begin
    term_nx.err  = berr_s;
    term_nx.port = berr_s ? '0 : ack_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_q <= '0;
      cinh_q <= 1'b0;
    end else if (take_term) begin
      term_q <= term_nx;
      cinh_q <= !write_q && bus_cinh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   rdata_q <= '0;
    else if (take_data && !write_q && !term_q.err) rdata_q <= bus_din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end
endmodule

// File: rtl/bus_seq_master.sv
module bus_seq_master
  import bseq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic [ACK_W-1:0]  rsp_port,
  output logic              rsp_cinh,
  output logic              bus_clk,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rnw,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_astb,
  output logic              bus_dstb,
  input  logic [DATA_W-1:0] bus_din,
  input  logic [ACK_W-1:0]  bus_ack,
  input  logic              bus_berr,
  input  logic              bus_cinh
);
  localparam int SYNC_W = ACK_W + 1;

  logic              phase_hi, accept, take_term, take_data, finish;
  logic              astb, dstb_late, write_q;
  logic [SYNC_W-1:0] sync_q;
  logic [ACK_W-1:0]  ack_s;
  logic              berr_s;
  logic [DATA_W-1:0] wdata_q;
  term_t             term_q;

  bseq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (phase_hi),
    .d    ({bus_berr, bus_ack}),
    .q    (sync_q)
  );
  assign berr_s = sync_q[SYNC_W-1];
  assign ack_s  = sync_q[ACK_W-1:0];

  bseq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .ack_s    (ack_s),
    .berr_s   (berr_s),
    .phase_hi (phase_hi),
    .req_ready(req_ready),
    .accept   (accept),
    .take_term(take_term),
    .take_data(take_data),
    .finish   (finish),
    .astb     (astb),
    .dstb_late(dstb_late)
  );

  bseq_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .take_term(take_term),
    .take_data(take_data),
    .finish   (finish),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .ack_s    (ack_s),
    .berr_s   (berr_s),
    .bus_din  (bus_din),
    .bus_cinh (bus_cinh),
    .write_q  (write_q),
    .addr_q   (bus_addr),
    .wdata_q  (wdata_q),
    .rdata_q  (rsp_data),
    .term_q   (term_q),
    .cinh_q   (rsp_cinh),
    .done_q   (rsp_valid)
  );

  assign bus_clk  = phase_hi;
  assign bus_rnw  = !write_q;
  assign bus_dout = write_q ? wdata_q : '0;
  assign bus_astb = astb;
  assign bus_dstb = write_q ? dstb_late : astb;
  assign rsp_err  = term_q.err;
  assign rsp_port = term_q.port;
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_clk,
  input logic              bus_astb,
  input logic              bus_dstb,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [1:0]        rsp_port
);
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_astb && !bus_clk);

  p_dstb_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dstb |-> bus_astb);

  p_astb_falls_rising_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_astb) |-> bus_clk);

  p_err_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_port == 2'b00));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_done_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_astb && $past(bus_astb));

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_astb && $past(bus_astb)) |-> $stable(bus_addr));
endmodule

bind bus_seq_master bseq_checker #(.ADDR_W(ADDR_W)) u_bseq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_clk  (bus_clk),
  .bus_astb (bus_astb),
  .bus_dstb (bus_dstb),
  .bus_addr (bus_addr),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_err  (rsp_err),
  .rsp_port (rsp_port)
);

// File: tb/test_bus_seq_master.sv
module test_bus_seq_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_err;
  logic [1:0]  rsp_port;
  logic        rsp_cinh;
  logic        bus_clk;
  logic [31:0] bus_addr;
  logic        bus_rnw;
  logic [31:0] bus_dout;
  logic        bus_astb;
  logic        bus_dstb;
  logic [31:0] bus_din = '0;
  logic [1:0]  bus_ack = '0;
  logic        bus_berr = 1'b0;
  logic        bus_cinh = 1'b0;

  int          vectors = 0;
  int          fails = 0;
  logic [31:0] exp_rdata = '0;

  always #2 clk = ~clk;  // 250 MHz

  bus_seq_master i_bus_seq_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .rsp_port(rsp_port), .rsp_cinh(rsp_cinh),
    .bus_clk(bus_clk), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
    .bus_dout(bus_dout), .bus_astb(bus_astb), .bus_dstb(bus_dstb),
    .bus_din(bus_din), .bus_ack(bus_ack), .bus_berr(bus_berr),
    .bus_cinh(bus_cinh)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  // rd: read; code: ack code; be: bus error; d: half-clock offset after the
  // accepting edge at which the slave answers; hold: extra half-clocks the
  // answer stays up after the strobes drop; cm: 0 none, 1 cinh in window,
  // 2 cinh everywhere except the window
  task automatic run_cycle(input bit rd, input logic [31:0] a, input logic [31:0] wd,
                           input logic [1:0] code, input bit be, input int d,
                           input int hold, input int cm);
    int          k;
    int          last;
    int          tries;
    logic [31:0] pat;
    bit          es, ed;
    k    = (d + 1) / 2;
    last = 6 + 2 * k;
    pat  = (a * 32'd40503) ^ 32'hC3A5_0F96;
    tries = 0;
    @(negedge clk);
    while (!req_ready && tries < 100) begin
      @(negedge clk);
      tries++;
    end
    if (!req_ready) begin
      chk(1'b0, "R2 ready never rose", 0, 1);
      return;
    end
    req_valid = 1'b1;
    req_write = !rd;
    req_addr  = a;
    req_wdata = wd;
    bus_din   = ~pat;
    bus_cinh  = (cm == 2);
    @(posedge clk);  // accepting edge, S0 begins
    for (int j = 0; j <= last + hold; j++) begin
      @(negedge clk);
      if (j == 0) begin
        req_valid = 1'b0;
        req_addr  = ~a;
        req_wdata = ~wd;
        chk(bus_clk == 1'b1, "R2 bus_clk high in S0", bus_clk, 1);
      end
      if (j <= last) begin
        es = (j >= 1) && (j <= last - 1);
        ed = rd ? es : ((j >= 2) && (j <= last - 1));
        chk(bus_astb == es, "R3/R4 astb", bus_astb, es);
        chk(bus_dstb == ed, "R3 dstb", bus_dstb, ed);
        chk(rsp_valid == (j == last), "R4/R10 rsp_valid", rsp_valid, j == last);
        if (es) begin
          chk(bus_addr == a && bus_rnw == rd, "R11 addr/rnw", {bus_rnw, bus_addr}, {rd, a});
          if (!rd) chk(bus_dout == wd, "R11 dout", bus_dout, wd);
        end
      end
      if (j == last) begin
        chk(rsp_err == be, "R8 err", rsp_err, be);
        chk(rsp_port == (be ? 2'b00 : code), "R7/R8 port", rsp_port, be ? 2'b00 : code);
        if (rd && !be) exp_rdata = pat;
        chk(rsp_data == exp_rdata, "R5/R8 data", rsp_data, exp_rdata);
        chk(rsp_cinh == (rd && cm == 1), "R6 cinh", rsp_cinh, rd && cm == 1);
      end
      if (j > last) chk(req_ready == 1'b0, "R9 ready held off", req_ready, 0);
      // slave drives for the next edges
      bus_ack  = (j >= d && j < last + hold) ? code : 2'b00;
      bus_berr = (j >= d && j < last + hold) ? be : 1'b0;
      bus_din  = (j == 4 + 2 * k) ? pat : ~pat;
      if (cm == 1)      bus_cinh = (j == 3 + 2 * k);
      else if (cm == 2) bus_cinh = (j != 3 + 2 * k);
      else              bus_cinh = 1'b0;
    end
    bus_cinh = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(bus_astb == 0 && bus_dstb == 0, "R1 strobes idle", {bus_astb, bus_dstb}, 0);
    chk(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
    chk(rsp_data == 0, "R1 rsp_data", rsp_data, 0);
    @(negedge clk);
    chk(req_ready == !bus_clk, "R1 ready in low phase", req_ready, !bus_clk);
    // R9 an answer already on the line blocks new cycles
    bus_ack = 2'b11;
    repeat (6) @(negedge clk);
    chk(req_ready == 0, "R9 ready low with stale ack", req_ready, 0);
    @(negedge clk);
    chk(req_ready == 0, "R9 ready low with stale ack", req_ready, 0);
    bus_ack = 2'b00;
    repeat (6) @(negedge clk);
    chk(req_ready == !bus_clk, "R9 ready back after release", req_ready, !bus_clk);

    // sweep: direction x port code x answer offset
    for (int rw = 0; rw < 2; rw++)
      for (int c = 1; c < 4; c++)
        for (int d = 0; d < 6; d++)
          run_cycle(rw == 0, 32'h1000 + 32'(rw * 64 + c * 8 + d),
                    32'hA500_0000 + 32'(c * 16 + d), 2'(c), 1'b0, d, 0, (d % 3));
    // R8 bus error alone and together with an acknowledge
    for (int d = 0; d < 4; d++) begin
      run_cycle(1'b1, 32'h2000 + 32'(d), 32'h0, 2'b00, 1'b1, d, 0, 0);
      run_cycle(1'b1, 32'h2100 + 32'(d), 32'h0, 2'b10, 1'b1, d, 0, 1);
      run_cycle(1'b0, 32'h2200 + 32'(d), 32'h55AA_0000 + 32'(d), 2'b11, 1'b1, d, 0, 0);
    end
    // R9 slave keeps its answer after the strobes drop
    run_cycle(1'b1, 32'h3000, 32'h0, 2'b01, 1'b0, 0, 3, 0);
    run_cycle(1'b0, 32'h3004, 32'h1234_5678, 2'b10, 1'b0, 2, 5, 0);
    run_cycle(1'b1, 32'h3008, 32'h0, 2'b11, 1'b0, 1, 4, 1);

    summary();
    $finish;
  end
endmodule